// File: doc/BRIEF.md
# Buffered Serial Port with Register Bus

This block is a byte-oriented asynchronous serial port. Software sees four 32-bit word registers on a simple bus: address, write strobe, write data, read strobe and registered read data. Bytes written to the data word go into a 16-entry transmit queue, which a serializer drains onto the line. Bytes recovered from the receive line go into a 16-entry receive queue. Software takes them out by reading the same data word.

A programmable prescaler produces a sampling tick. Each bit period lasts a software-chosen number of ticks, so the line rate is clk / ((P+1) × S). Here P is the prescaler value and S is the number of samples per bit, and S must be at least 4. A frame has one start bit, eight data bits, an optional even or odd parity bit, and one or two stop bits. Software polls the status word: its upper bytes give live counts of free transmit slots and waiting receive bytes.

The receiver passes the line through a two-flop synchroniser. It waits for a falling edge between two ticks and confirms the start bit at mid-bit. It decides every bit by a majority of the three samples around mid-bit. A frame with a parity error or a low final stop bit is discarded.

Top module: `uart_mmio`

## Requirements
- R1: After reset, txd is high, the status word reads 0x0010_0000, the prescaler word reads 0 and the frame word reads 0x0000_0007.
- R2: Word index is bus_addr[3:2]: 0 data, 1 status, 2 prescaler, 3 frame. The prescaler word keeps bits 19:0 and reads back zero above them. The frame word keeps samples-minus-one in bits 7:0, parity mode in bits 9:8 and the stop count in bit 16, and reads back zero elsewhere. Read data appears the cycle after the read strobe.
- R3: The sampling tick fires once every P+1 clocks, so every transmitted bit lasts exactly (P+1) × S clocks, where S is frame bits 7:0 plus one.
- R4: The line idles high. A frame is a low start bit, then the eight data bits least-significant first, then the optional parity bit, then the high stop bit or bits. Queued bytes follow one another with no idle gap.
- R5: Status bits 23:16 hold 16 minus the transmit queue occupancy, and bits 31:24 hold the receive queue occupancy. All other status bits are zero.
- R6: A data write while the transmit queue is full is dropped, and the free count stays at zero.
- R7: A data read returns the oldest received byte in bits 7:0 and removes it. A data read with nothing waiting returns zero. A byte that completes while the receive queue holds 16 is discarded.
- R8: A single corrupted sample next to the middle of a received bit does not change the decoded bit.
- R9: A low pulse that is high again at the mid-point of the start bit starts no frame, and a correct frame after it is received.
- R10: A received frame with a wrong parity bit or a low final stop bit is not queued.
- R11: Parity mode 1 makes the parity bit the XOR of the data, so the count of ones is even. Mode 2 sends its inverse, for odd parity. Modes 0 and 3 send no parity bit. Stop bit 16 set gives two stop bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address; bits 3:2 pick the word |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; a data read pops the receive queue |
| bus_rdata | output | 32 | Registered read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
The transmit line is decoded from its own waveform for every mix of two prescalers, two oversampling ratios, three parity modes and both stop counts, and all 256 byte values are looped back. If the tick spacing or the bit length were off, the mid-bit samples would drift into the neighbouring bit. A wrong parity polarity or bit order would show up in the decoded frame. Both queues are overfilled: a design that wrapped its pointers would lose or repeat bytes, and one that returned stale data would break the zero-on-empty read. Hand-built frames then inject a bad parity bit, a low stop bit, a short start glitch and a one-sample spike in each data bit. These catch a receiver that queues bad frames, starts on noise or trusts a single sample.

// File: rtl/uart_pkg.sv
package uart_pkg;
    localparam int DATA_W  = 8;
    localparam int PRESC_W = 20;
    localparam int BUS_W   = 32;
    localparam int REG_AW  = 4;
    localparam int BIT_IDX_W = $clog2(DATA_W);

    typedef enum logic [1:0] {
        WORD_DATA  = 2'd0,
        WORD_STAT  = 2'd1,
        WORD_PRESC = 2'd2,
        WORD_FRAME = 2'd3
    } word_sel_e;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } parity_e;

    typedef struct packed {
        logic    two_stop;
        parity_e parity;
        logic [7:0] spb_m1;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_PAR,
        LN_STOP
    } line_st_e;

    localparam frame_cfg_t FRAME_RESET = '{two_stop: 1'b0, parity: PAR_NONE, spb_m1: 8'd7};

    function automatic logic par_on(input parity_e p);
        return (p == PAR_EVEN) || (p == PAR_ODD);
    endfunction

    function automatic logic par_bit(input logic [DATA_W-1:0] d, input parity_e p);
        return (p == PAR_ODD) ? ~^d : ^d;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_tick.sv
module uart_tick #(
    parameter int PW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] presc,
    output logic          tick
);
    logic [PW-1:0] cnt;

    assign tick = (cnt >= presc);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_tx.sv
module uart_tx
    import uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              have_data,
    input  logic [DATA_W-1:0] data,
    output logic              pop,
    output logic              txd,
    output logic              idle
);
    line_st_e               st;
    logic [7:0]             k;
    logic [DATA_W-1:0]      sh;
    logic [BIT_IDX_W-1:0]   bi;
    logic                   par_q, sidx;
    logic                   bit_end, last_stop;

    assign bit_end   = tick && (k == cfg.spb_m1);
    assign last_stop = (st == LN_STOP) && (!cfg.two_stop || sidx);
    assign pop       = tick && have_data &&
                       ((st == LN_IDLE) || (last_stop && bit_end));
    assign idle      = (st == LN_IDLE);

    always_comb begin
        case (st)
            LN_START: txd = 1'b0;
            LN_DATA:  txd = sh[0];
            LN_PAR:   txd = par_q;
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= LN_IDLE;
            k     <= '0;
            sh    <= '0;
            bi    <= '0;
            par_q <= 1'b0;
            sidx  <= 1'b0;
        end else if (pop) begin
            sh    <= data;
            par_q <= par_bit(data, cfg.parity);
            st    <= LN_START;
            k     <= '0;
            sidx  <= 1'b0;
        end else if (st != LN_IDLE && tick) begin
            k <= bit_end ? 8'd0 : k + 8'd1;
            if (bit_end) begin
                case (st)
                    LN_START: begin
                        st <= LN_DATA;
                        bi <= '0;
                    end
                    LN_DATA: begin
                        sh <= sh >> 1;
                        bi <= bi + 1'b1;
                        if (bi == BIT_IDX_W'(DATA_W-1))
                            st <= par_on(cfg.parity) ? LN_PAR : LN_STOP;
                    end
                    LN_PAR:  st <= LN_STOP;
                    LN_STOP: begin
                        if (last_stop) st <= LN_IDLE;
                        else           sidx <= 1'b1;
                    end
                    default: st <= LN_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              rxd,
    input  frame_cfg_t        cfg,
    output logic              push,
    output logic [DATA_W-1:0] byte_out
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= rxd;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '1;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            end
        end
    endgenerate

    assign lvl = sync_q[SYNC_STAGES-1];

    line_st_e             st;
    logic [7:0]           k;
    logic [8:0]           nsamp;
    logic [7:0]           mid, mid_lo, mid_hi;
    logic                 a_q, b_q, v_q, prev_q, perr_q, serr_q, sidx_q;
    logic [BIT_IDX_W-1:0] bi;
    logic [DATA_W-1:0]    sh;
    logic                 vnow, last, at_vote, final_stop;

    assign nsamp      = {1'b0, cfg.spb_m1} + 9'd1;
    assign mid        = nsamp[8:1];
    assign mid_lo     = mid - 8'd1;
    assign mid_hi     = mid + 8'd1;
    assign last       = (k == cfg.spb_m1);
    assign at_vote    = (k == mid_hi);
    assign vnow       = at_vote ? maj3(a_q, b_q, lvl) : v_q;
    assign final_stop = (st == LN_STOP) && (!cfg.two_stop || sidx_q);
    assign byte_out   = sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= LN_IDLE;
            k      <= '0;
            a_q    <= 1'b1;
            b_q    <= 1'b1;
            v_q    <= 1'b1;
            prev_q <= 1'b1;
            perr_q <= 1'b0;
            serr_q <= 1'b0;
            sidx_q <= 1'b0;
            bi     <= '0;
            sh     <= '0;
            push   <= 1'b0;
        end else begin
            push <= 1'b0;
            if (tick) begin
                prev_q <= lvl;
                if (st == LN_IDLE) begin
                    if (prev_q && !lvl) begin
                        st     <= LN_START;
                        k      <= 8'd1;
                        perr_q <= 1'b0;
                        serr_q <= 1'b0;
                        sidx_q <= 1'b0;
                        bi     <= '0;
                    end
                end else begin
                    k <= last ? 8'd0 : k + 8'd1;
                    if (k == mid_lo) a_q <= lvl;
                    if (k == mid)    b_q <= lvl;
                    if (at_vote)     v_q <= vnow;
                    if (st == LN_START && k == mid && lvl) begin
                        st <= LN_IDLE;
                    end else if (final_stop && at_vote) begin
                        st   <= LN_IDLE;
                        push <= vnow && !perr_q && !serr_q;
                    end else if (last) begin
                        case (st)
                            LN_START: st <= vnow ? LN_IDLE : LN_DATA;
                            LN_DATA: begin
                                sh <= {vnow, sh[DATA_W-1:1]};
                                bi <= bi + 1'b1;
                                if (bi == BIT_IDX_W'(DATA_W-1))
                                    st <= par_on(cfg.parity) ? LN_PAR : LN_STOP;
                            end
                            LN_PAR: begin
                                perr_q <= (vnow != par_bit(sh, cfg.parity));
                                st     <= LN_STOP;
                            end
                            LN_STOP: begin
                                serr_q <= !vnow;
                                sidx_q <= 1'b1;
                            end
                            default: st <= LN_IDLE;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/uart_mmio.sv
module uart_mmio
    import uart_pkg::*;
#(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_re,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              rxd,
    output logic              txd
);
    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    word_sel_e         word;
    logic [PRESC_W-1:0] div_q;
    frame_cfg_t        cfg_q;
    logic              div_wr, tick;

    logic [CNT_W-1:0]  tx_cnt, rx_cnt;
    logic [DATA_W-1:0] tx_dout, rx_dout, rx_byte;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_pop, tx_idle, rx_push, tx_push, rx_pop;
    logic              unused_bits;

    assign word        = word_sel_e'(bus_addr[3:2]);
    assign div_wr      = bus_we && (word == WORD_PRESC);
    assign tx_push     = bus_we && (word == WORD_DATA);
    assign rx_pop      = bus_re && (word == WORD_DATA);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:20], tx_full, rx_full};

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cfg_q <= FRAME_RESET;
        end else if (bus_we) begin
            if (word == WORD_PRESC) div_q <= bus_wdata[PRESC_W-1:0];
            if (word == WORD_FRAME)
                cfg_q <= '{two_stop: bus_wdata[16],
                           parity:   parity_e'(bus_wdata[9:8]),
                           spb_m1:   bus_wdata[7:0]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            case (word)
                WORD_DATA:  bus_rdata <= rx_empty ? '0 : BUS_W'(rx_dout);
                WORD_STAT:  bus_rdata <= {8'(rx_cnt), 8'(FIFO_DEPTH - int'(tx_cnt)), 16'd0};
                WORD_PRESC: bus_rdata <= BUS_W'(div_q);
                default:    bus_rdata <= {15'd0, cfg_q.two_stop, 6'd0, cfg_q.parity, cfg_q.spb_m1};
            endcase
        end
    end

    uart_tick #(.PW(PRESC_W)) u_tick (
        .clk(clk), .rst(rst), .presc(div_q), .tick(tick)
    );

    uart_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst(rst), .push(tx_push), .din(bus_wdata[DATA_W-1:0]),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    uart_tx u_tx (
        .clk(clk), .rst(rst), .tick(tick), .cfg(cfg_q), .have_data(!tx_empty),
        .data(tx_dout), .pop(tx_pop), .txd(txd), .idle(tx_idle)
    );

    uart_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .cfg(cfg_q),
        .push(rx_push), .byte_out(rx_byte)
    );

    uart_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst(rst), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_dout), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );
endmodule

// File: rtl/uart_mmio_chk.sv
module uart_mmio_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       bus_addr,
    input logic             bus_we,
    input logic             bus_re,
    input logic [31:0]      bus_rdata,
    input logic             txd,
    input logic             tx_idle,
    input logic             tick,
    input logic             tx_pop,
    input logic             div_wr,
    input logic [19:0]      div_q,
    input logic [CNT_W-1:0] tx_cnt,
    input logic [CNT_W-1:0] rx_cnt
);
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> txd);

    assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && div_q != 20'd0 && !div_wr) |=> !tick);

    assert_status_free_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr[3:2] == 2'd1) |=> (bus_rdata[23:16] == 8'(FIFO_DEPTH - int'($past(tx_cnt)))));

    assert_full_write_dropped_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr[3:2] == 2'd0 && tx_cnt == CNT_W'(FIFO_DEPTH) && !tx_pop) |=> $stable(tx_cnt));

    assert_empty_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr[3:2] == 2'd0 && rx_cnt == '0) |=> (bus_rdata == 32'd0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_cnt <= CNT_W'(FIFO_DEPTH)) && (tx_cnt <= CNT_W'(FIFO_DEPTH)));
endmodule

bind uart_mmio uart_mmio_chk #(.FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .txd(txd), .tx_idle(tx_idle), .tick(tick), .tx_pop(tx_pop),
    .div_wr(div_wr), .div_q(div_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/tb_uart_mmio.sv
module tb_uart_mmio;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  addr = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        txd;
    logic        loop_en = 1'b1, drv_rx = 1'b1;
    logic        rxd;
    int checks = 0, errors = 0;
    int cur_p = 0, cur_s = 8, cur_par = 0, cur_stop = 0;
    bit done = 0;

    always #4 clk = ~clk;
    assign rxd = loop_en ? txd : drv_rx;

    uart_mmio dut (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wdata),
        .bus_re(re), .bus_rdata(rdata), .rxd(rxd), .txd(txd)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_p = 0; cur_s = 8; cur_par = 0; cur_stop = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; we = 1'b1;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; re = 1'b1;
        @(negedge clk); re = 1'b0; d = rdata;
    endtask

    task automatic setup(input int p, input int s, input int par, input int stp);
        wr(4'h8, 32'(p));
        wr(4'hC, 32'((s - 1) | (par << 8) | (stp << 16)));
        cur_p = p; cur_s = s; cur_par = par; cur_stop = stp;
    endtask

    function automatic logic exp_par(input logic [7:0] b, input int par);
        return (par == 2) ? ~^b : ^b;
    endfunction

    task automatic wait_occ(input int n, input string req);
        logic [31:0] st;
        int tries = 0;
        rd(4'h4, st);
        while (int'(st[31:24]) != n && tries < 20000) begin
            rd(4'h4, st);
            tries++;
        end
        chk(req, 32'(st[31:24]), 32'(n));
    endtask

    task automatic wait_low();
        int n = 0;
        while (txd !== 1'b0 && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic measure_width(input string req);
        int cnt = 0;
        wait_low();
        while (txd === 1'b0 && cnt < 20000) begin @(negedge clk); cnt++; end
        chk(req, 32'(cnt), 32'((cur_p + 1) * cur_s));
    endtask

    task automatic measure_tx(input logic [7:0] b);
        int bl = (cur_p + 1) * cur_s;
        wait_low();
        repeat (bl / 2) @(negedge clk);
        chk("R4 start bit", 32'(txd), 32'd0);
        for (int i = 0; i < 8; i++) begin
            repeat (bl) @(negedge clk);
            chk("R4 data bit lsb first", 32'(txd), 32'(b[i]));
        end
        if (cur_par == 1 || cur_par == 2) begin
            repeat (bl) @(negedge clk);
            chk("R11 parity bit", 32'(txd), 32'(exp_par(b, cur_par)));
        end
        for (int i = 0; i <= cur_stop; i++) begin
            repeat (bl) @(negedge clk);
            chk("R11 stop bit", 32'(txd), 32'd1);
        end
    endtask

    task automatic drive_bit(input logic v, input bit spike);
        int bl = (cur_p + 1) * cur_s;
        drv_rx = v;
        if (!spike) begin
            repeat (bl) @(negedge clk);
        end else begin
            repeat (bl / 2 - 1) @(negedge clk);
            drv_rx = ~v;
            repeat (cur_p + 1) @(negedge clk);
            drv_rx = v;
            repeat (bl - bl / 2 - 1 - (cur_p + 1)) @(negedge clk);
        end
    endtask

    task automatic send_rx(input logic [7:0] b, input bit flip_par, input bit bad_stop, input int spike_at);
        @(negedge clk);
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i], spike_at == i);
        if (cur_par == 1 || cur_par == 2) drive_bit(exp_par(b, cur_par) ^ flip_par, 1'b0);
        if (cur_stop != 0) drive_bit(1'b1, 1'b0);
        drive_bit(!bad_stop, 1'b0);
        drv_rx = 1'b1;
        repeat ((cur_p + 1) * cur_s * 2) @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int idx;
        do_reset();

        // R1: reset state
        chk("R1 txd idle", 32'(txd), 32'd1);
        rd(4'h4, v); chk("R1 status", v, 32'h0010_0000);
        rd(4'h8, v); chk("R1 prescaler", v, 32'd0);
        rd(4'hC, v); chk("R1 frame", v, 32'd7);

        // R2: register map and readback masks
        wr(4'h8, 32'hFFFF_FFFF); rd(4'h8, v); chk("R2 prescaler mask", v, 32'h000F_FFFF);
        wr(4'hC, 32'hFFFF_FFFF); rd(4'hC, v); chk("R2 frame mask", v, 32'h0001_03FF);
        wr(4'h4, 32'hFFFF_FFFF); rd(4'h4, v); chk("R2 status not writable", v, 32'h0010_0000);
        do_reset();

        // R7: empty read
        rd(4'h0, v); chk("R7 empty read zero", v, 32'd0);

        // R3 R4 R11: sweep of line settings with loopback
        idx = 0;
        for (int p = 0; p <= 2; p += 2)
            for (int s = 4; s <= 8; s += 4)
                for (int par = 0; par < 3; par++)
                    for (int stp = 0; stp < 2; stp++) begin
                        logic [7:0] b1, b2;
                        b1 = 8'(8'h35 + idx * 14) | 8'h01;
                        b2 = 8'(8'hA6 ^ (idx * 37));
                        setup(p, s, par, stp);
                        wr(4'h0, 32'(b1));
                        measure_width("R3 bit length");
                        wait_occ(1, "R7 loopback count");
                        repeat ((p + 1) * s * 2) @(negedge clk);
                        wr(4'h0, 32'(b2));
                        measure_tx(b2);
                        wait_occ(2, "R7 loopback count");
                        rd(4'h0, v); chk("R7 oldest first", v, 32'(b1));
                        rd(4'h0, v); chk("R7 second byte", v, 32'(b2));
                        idx++;
                    end

        // R4 R7: all byte values looped back, reserved parity mode acts as none (R11)
        setup(0, 4, 3, 0);
        for (int batch = 0; batch < 16; batch++) begin
            for (int i = 0; i < 16; i++) wr(4'h0, 32'(batch * 16 + i));
            wait_occ(16, "R4 batch arrival");
            for (int i = 0; i < 16; i++) begin
                rd(4'h0, v); chk("R4 loopback byte", v, 32'(batch * 16 + i));
            end
        end

        // R5 R6: free count with a slow line
        do_reset();
        setup(1000, 4, 0, 0);
        wr(4'h0, 32'h11);
        repeat (2100) @(negedge clk);
        for (int i = 0; i < 5; i++) wr(4'h0, 32'(i));
        rd(4'h4, v); chk("R5 status counts", v, 32'h000B_0000);
        for (int i = 0; i < 11; i++) wr(4'h0, 32'(i));
        rd(4'h4, v); chk("R5 full status", v, 32'h0000_0000);
        wr(4'h0, 32'h77);
        rd(4'h4, v); chk("R6 full write dropped", v, 32'h0000_0000);

        // R6 R7: overfill both queues
        do_reset();
        setup(0, 8, 0, 0);
        for (int i = 0; i < 18; i++) wr(4'h0, 32'(8'h40 + i));
        rd(4'h4, v); chk("R6 tx full after overfill", 32'(v[23:16]), 32'd0);
        wait_occ(16, "R7 rx fills");
        repeat (400) @(negedge clk);
        rd(4'h4, v); chk("R7 rx full keeps 16", 32'(v[31:24]), 32'd16);
        for (int i = 0; i < 16; i++) begin
            rd(4'h0, v); chk("R7 order after overflow", v, 32'(8'h40 + i));
        end
        rd(4'h4, v); chk("R7 drained", v, 32'h0010_0000);
        rd(4'h0, v); chk("R7 empty read zero", v, 32'd0);

        // R8 R9 R10: hand-built receive frames
        do_reset();
        loop_en = 1'b0;
        setup(1, 8, 1, 0);
        send_rx(8'h5A, 1'b1, 1'b0, -1);
        rd(4'h4, v); chk("R10 bad parity dropped", 32'(v[31:24]), 32'd0);
        send_rx(8'h3C, 1'b0, 1'b1, -1);
        rd(4'h4, v); chk("R10 low stop dropped", 32'(v[31:24]), 32'd0);
        @(negedge clk); drv_rx = 1'b0;
        repeat (4) @(negedge clk); drv_rx = 1'b1;
        repeat (48) @(negedge clk);
        rd(4'h4, v); chk("R9 glitch rejected", 32'(v[31:24]), 32'd0);
        send_rx(8'hC3, 1'b0, 1'b0, -1);
        rd(4'h0, v); chk("R9 frame after glitch", v, 32'hC3);
        for (int i = 0; i < 8; i++) begin
            send_rx(8'h96 ^ 8'(i), 1'b0, 1'b0, i);
            rd(4'h0, v); chk("R8 spike voted out", v, 32'(8'h96 ^ 8'(i)));
        end
        setup(1, 8, 2, 1);
        send_rx(8'h71, 1'b0, 1'b0, -1);
        rd(4'h0, v); chk("R11 odd parity two stops", v, 32'h71);
        send_rx(8'h71, 1'b1, 1'b0, -1);
        rd(4'h4, v); chk("R10 odd parity error dropped", 32'(v[31:24]), 32'd0);
        send_rx(8'h2E, 1'b0, 1'b1, -1);
        rd(4'h4, v); chk("R10 second stop low dropped", 32'(v[31:24]), 32'd0);

        done = 1;
        summary();
        $finish;
    end
endmodule